// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Move Sequencer

This block steps one register move operation across a vector of elements under two independent predicate masks. The source mask picks which source elements are consumed, as in a compress. The destination mask picks which destination elements receive a value, as in an expand. Each side keeps its own element index. Before every transfer, each index skips forward past its own clear mask bits, and the two sides are paired in ascending order.

A request is accepted on `start` while the block is idle. The request gives the two base registers, a vector/scalar tag for each side, the element count `vl` and the two masks. The block then issues one read/write register pair per clock on its transfer outputs. A scalar-tagged side always addresses its base register. A scalar destination ends the operation after its first transfer. A scalar source with several destination bits set broadcasts one value. A single set bit in either mask gives insert or select behaviour. `done` pulses for one cycle when the operation ends.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, `busy`, `xfer_valid` and `done` are low.
- R2: `start` is sampled only while `busy` is low, and all request inputs are captured at that edge. A `start` that arrives while `busy` is high changes neither the transfers that follow nor the time at which the operation ends.
- R3: Transfer k pairs the k-th set bit of the source mask with the k-th set bit of the destination mask. Both counts are in ascending element order, and only bits below `vl` are counted. Bit i of each mask belongs to element i.
- R4: `xfer_src_reg` is `src_base` plus the source element index when `src_vec` is 1, and `src_base` when it is 0. `xfer_dst_reg` is formed the same way from `dst_base`, `dst_vec` and the destination element index. Both sums wrap modulo 2^REG_AW.
- R5: A scalar source (`src_vec`=0) keeps its index on its first set mask bit. Every destination element selected by the destination mask then receives the same source register.
- R6: A scalar destination (`dst_vec`=0) ends the operation on its first transfer. `done` rises in the same cycle as that transfer, and `xfer_dst_reg` equals `dst_base`.
- R7: With a vector destination, the operation ends when either side has no further set mask bit below `vl`. `done` pulses for one cycle, one cycle after the last transfer, and no transfer is issued for the remaining destination elements.
- R8: The first transfer appears in the cycle after the clock edge that follows the one sampling `start`. Subsequent transfers follow on consecutive cycles, at most one per cycle.
- R9: If `vl` is 0, or either mask has no set bit below `vl`, no transfer occurs. `done` then appears at the same point where a first transfer would have appeared.
- R10: Mask bits at positions `vl` and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| src_base | input | REG_AW | Source base register |
| dst_base | input | REG_AW | Destination base register |
| src_vec | input | 1 | 1: source is a vector, 0: scalar |
| dst_vec | input | 1 | 1: destination is a vector, 0: scalar |
| vl | input | $clog2(NELEM+1) | Element count |
| src_mask | input | NELEM | Source predicate, bit i for element i |
| dst_mask | input | NELEM | Destination predicate, bit i for element i |
| busy | output | 1 | Operation in progress |
| xfer_valid | output | 1 | A move request is presented this cycle |
| xfer_src_reg | output | REG_AW | Register to read |
| xfer_dst_reg | output | REG_AW | Register to write |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench targets the pairings where both masks have gaps in different places. A design that advanced both indices together, or let one side skip for the other, would issue reads and writes to the wrong registers. It drives scalar sources against multi-bit destination masks and scalar destinations behind leading zero source bits. A broken index hold or early exit would then show up as a walking read register or extra writes. It also covers `vl` of zero, empty masks, masks with stray bits above `vl`, and base wrap-around. A stray `start` during a run would restart or corrupt the sequence if it were not ignored.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NSIDES   = 2;
endpackage

// File: rtl/tpm_seek.sv
// Finds the lowest set mask position at or above 'from' and below 'limit'.
module tpm_seek #(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    input  logic [IW-1:0] limit,
    output logic          found,
    output logic [IW-1:0] pos
);
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from) && (IW'(i) < limit)) begin
                found = 1'b1;
                pos   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tpm_addr.sv
// Register number for one side: base plus element index when vector-tagged.
module tpm_addr #(
    parameter int IW     = 4,
    parameter int REG_AW = 7
) (
    input  logic [REG_AW-1:0] base,
    input  logic              is_vec,
    input  logic [IW-1:0]     elem,
    output logic [REG_AW-1:0] regno
);
    always_comb begin
        regno = is_vec ? (base + REG_AW'(elem)) : base;
    end
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
    parameter int NELEM  = 8,
    parameter int REG_AW = 7,
    localparam int IW    = $clog2(NELEM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_AW-1:0] src_base,
    input  logic [REG_AW-1:0] dst_base,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [IW-1:0]     vl,
    input  logic [NELEM-1:0]  src_mask,
    input  logic [NELEM-1:0]  dst_mask,
    output logic              busy,
    output logic              xfer_valid,
    output logic [REG_AW-1:0] xfer_src_reg,
    output logic [REG_AW-1:0] xfer_dst_reg,
    output logic              done
);
    import tpm_pkg::*;

    typedef struct packed {
        phase_e                              phase;
        logic [NSIDES-1:0][NELEM-1:0]        mask;
        logic [NSIDES-1:0][IW-1:0]           idx;
        logic [NSIDES-1:0]                   vec;
        logic [NSIDES-1:0][REG_AW-1:0]       base;
        logic [IW-1:0]                       len;
        logic                                xfer;
        logic [REG_AW-1:0]                   rreg;
        logic [REG_AW-1:0]                   wreg;
        logic                                fin;
    } state_t;

    state_t st_q, st_d;

    logic [NSIDES-1:0]              hit;
    logic [NSIDES-1:0][IW-1:0]      pos;
    logic [NSIDES-1:0][REG_AW-1:0]  regno;

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        tpm_seek #(.N(NELEM), .IW(IW)) u_seek (
            .mask  (st_q.mask[s]),
            .from  (st_q.idx[s]),
            .limit (st_q.len),
            .found (hit[s]),
            .pos   (pos[s])
        );
        tpm_addr #(.IW(IW), .REG_AW(REG_AW)) u_addr (
            .base   (st_q.base[s]),
            .is_vec (st_q.vec[s]),
            .elem   (pos[s]),
            .regno  (regno[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.xfer = 1'b0;
        st_d.fin  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase          = PH_RUN;
                    st_d.idx            = '0;
                    st_d.len            = vl;
                    st_d.mask[SIDE_SRC] = src_mask;
                    st_d.mask[SIDE_DST] = dst_mask;
                    st_d.vec[SIDE_SRC]  = src_vec;
                    st_d.vec[SIDE_DST]  = dst_vec;
                    st_d.base[SIDE_SRC] = src_base;
                    st_d.base[SIDE_DST] = dst_base;
                end
            end
            PH_RUN: begin
                if (&hit) begin
                    st_d.xfer = 1'b1;
                    st_d.rreg = regno[SIDE_SRC];
                    st_d.wreg = regno[SIDE_DST];
                    for (int s = 0; s < NSIDES; s++) begin
                        st_d.idx[s] = st_q.vec[s] ? (pos[s] + IW'(1)) : pos[s];
                    end
                    if (!st_q.vec[SIDE_DST]) begin
                        st_d.phase = PH_IDLE;
                        st_d.fin   = 1'b1;
                    end
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.fin   = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.phase == PH_RUN);
    assign xfer_valid   = st_q.xfer;
    assign xfer_src_reg = st_q.rreg;
    assign xfer_dst_reg = st_q.wreg;
    assign done         = st_q.fin;
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker #(
    parameter int REG_AW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dst_vec,
    input logic [REG_AW-1:0] dst_base,
    input logic              busy,
    input logic              xfer_valid,
    input logic [REG_AW-1:0] xfer_dst_reg,
    input logic              done
);
    logic              cap_dvec;
    logic [REG_AW-1:0] cap_dbase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dvec  <= 1'b1;
            cap_dbase <= '0;
        end else if (start && !busy) begin
            cap_dvec  <= dst_vec;
            cap_dbase <= dst_base;
        end
    end

    p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_scalar_dst_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !cap_dvec) |-> (done && xfer_dst_reg == cap_dbase));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_xfer_in_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> $past(busy));
endmodule

bind twin_pred_mover tpm_checker #(.REG_AW(REG_AW)) u_tpm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dst_vec      (dst_vec),
    .dst_base     (dst_base),
    .busy         (busy),
    .xfer_valid   (xfer_valid),
    .xfer_dst_reg (xfer_dst_reg),
    .done         (done)
);

// File: tb/twin_pred_mover_test.sv
`timescale 1ns/1ps
module twin_pred_mover_test;
    localparam int N  = 8;
    localparam int AW = 7;
    localparam int IW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic          src_vec = 1'b0, dst_vec = 1'b0;
    logic [IW-1:0] vl = '0;
    logic [N-1:0]  src_mask = '0, dst_mask = '0;
    logic          busy, xfer_valid, done;
    logic [AW-1:0] xfer_src_reg, xfer_dst_reg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    twin_pred_mover #(.NELEM(N), .REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec), .vl(vl),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .busy(busy), .xfer_valid(xfer_valid),
        .xfer_src_reg(xfer_src_reg), .xfer_dst_reg(xfer_dst_reg),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: list the set positions on each side, pair them in order.
    task automatic run_op(input logic [AW-1:0] sb, input logic [AW-1:0] db,
                          input bit sv, input bit dv, input int len,
                          input logic [N-1:0] sm, input logic [N-1:0] dm,
                          input bit interfere, input string req);
        int sl[$];
        int dl[$];
        int er[$];
        int ew[$];
        int cnt;
        int ncyc;
        for (int i = 0; i < N && i < len; i++) begin
            if (sm[i]) sl.push_back(i);
            if (dm[i]) dl.push_back(i);
        end
        if (sl.size() == 0 || dl.size() == 0) cnt = 0;
        else if (!dv) cnt = 1;
        else if (!sv) cnt = dl.size();
        else cnt = (sl.size() < dl.size()) ? sl.size() : dl.size();
        for (int k = 0; k < cnt; k++) begin
            er.push_back(int'(AW'(sv ? sb + AW'(sl[k]) : sb)));
            ew.push_back(int'(AW'(dv ? db + AW'(dl[k]) : db)));
        end
        ncyc = dv ? cnt + 1 : 1;

        @(negedge clk);
        src_base = sb; dst_base = db; src_vec = sv; dst_vec = dv;
        vl = IW'(len); src_mask = sm; dst_mask = dm; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", busy, 1);
        chk(xfer_valid === 1'b0, "R8", "no transfer on capture edge", xfer_valid, 0);
        for (int c = 1; c <= ncyc; c++) begin
            if (interfere && c == 1 && ncyc >= 2) begin
                start = 1'b1; src_base = ~sb; dst_base = ~db;
                src_mask = ~sm; dst_mask = ~dm; src_vec = ~sv; dst_vec = ~dv;
                vl = IW'(N);
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            chk(xfer_valid === (c <= cnt), req, "xfer_valid", xfer_valid, c <= cnt);
            if (c <= cnt) begin
                chk(int'(xfer_src_reg) == er[c-1], req, "src reg",
                    int'(xfer_src_reg), er[c-1]);
                chk(int'(xfer_dst_reg) == ew[c-1], req, "dst reg",
                    int'(xfer_dst_reg), ew[c-1]);
            end
            chk(done === (c == ncyc), req, "done", done, c == ncyc);
            chk(busy === (c < ncyc), req, "busy", busy, c < ncyc);
        end
        @(negedge clk);
        chk(done === 1'b0 && xfer_valid === 1'b0 && busy === 1'b0, req,
            "quiet after end", {busy, xfer_valid, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
        chk(xfer_valid === 1'b0, "R1", "xfer_valid in reset", xfer_valid, 0);
        chk(done === 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", busy, 0);

        // R4 R8: plain vector copy, all elements
        run_op(7'd10, 7'd40, 1, 1, 8, 8'hFF, 8'hFF, 0, "R4");
        // R3: compress (dst all ones)
        run_op(7'd0, 7'd20, 1, 1, 8, 8'b1010_0110, 8'hFF, 0, "R3");
        // R3: expand (src all ones)
        run_op(7'd5, 7'd50, 1, 1, 8, 8'hFF, 8'b1001_0010, 0, "R3");
        // R3: twin predication, different gaps
        run_op(7'd3, 7'd60, 1, 1, 7, 8'b0110_1001, 8'b1100_0110, 0, "R3");
        // R6: scalar destination after leading zero source bits
        run_op(7'd30, 7'd90, 1, 0, 8, 8'b0001_0000, 8'hFF, 0, "R6");
        // R6: scalar destination, dst mask gap
        run_op(7'd30, 7'd91, 1, 0, 8, 8'b0000_0110, 8'b0010_0000, 0, "R6");
        // R5: scalar source splat across several destination bits
        run_op(7'd12, 7'd70, 0, 1, 8, 8'b0000_1000, 8'b1101_0100, 0, "R5");
        // R5: insert, single destination bit
        run_op(7'd12, 7'd70, 0, 1, 8, 8'hFF, 8'b0000_0100, 0, "R5");
        // R9: vl zero
        run_op(7'd1, 7'd2, 1, 1, 0, 8'hFF, 8'hFF, 0, "R9");
        // R9: empty source mask
        run_op(7'd1, 7'd2, 1, 1, 8, 8'h00, 8'hFF, 0, "R9");
        // R10: bits above vl ignored
        run_op(7'd8, 7'd16, 1, 1, 4, 8'b1111_0101, 8'b1110_1011, 0, "R10");
        // R10: only bits above vl set
        run_op(7'd8, 7'd16, 1, 1, 3, 8'b1111_0000, 8'hFF, 0, "R10");
        // R7: source runs out first
        run_op(7'd0, 7'd100, 1, 1, 8, 8'b0000_0011, 8'hFF, 0, "R7");
        // R2: start while busy ignored
        run_op(7'd4, 7'd44, 1, 1, 8, 8'b1011_0101, 8'b0111_1100, 1, "R2");
        // R4: base wrap-around
        run_op(7'd125, 7'd126, 1, 1, 8, 8'hFF, 8'b1000_0101, 0, "R4");
        // R8: back-to-back operations, mixed patterns
        for (int t = 0; t < 6; t++) begin
            run_op(AW'(t * 19), AW'(t * 23 + 1), t[0], t[1] | t[2],
                   t + 3, N'(8'h5A ^ (t * 37)), N'(8'hC3 ^ (t * 11)), t[0], "R8");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule